// File: doc/BRIEF.md
# Source-Routed Credit-Flow Crossbar Switch

This block is the packet switch of a direct-network node. It has nine ports. Three ports face local functional units and six face external links. Any input can reach any output through a full crossbar. Packets travel as flits, and each flit carries a head flag and a tail flag beside its data word. The head flit holds the route. Its lowest 4-bit field names the output port for this hop. The switch consumes that field by shifting the head word right by 4 bits before the head leaves, so the next hop finds its own port number in the same place. Body flits and the tail flit follow the path the head opened and are not changed.

Each input keeps one queue for every output. A stalled destination therefore holds back only the flits queued for it. An input accepts a flit when the queue it is steered to has room. Each output has a round-robin arbiter. Once a head flit wins an output, that output stays with the same input until the tail flit has left. A flit is forwarded as soon as it reaches the head of its queue and wins its output, so a head flit can leave before its own tail has arrived.

The input side is a valid/ready stream. When `in_valid` is high and `in_ready` is low, the sender must keep the flit and its flags stable until `in_ready` goes high, and a flit is taken on a clock edge where both are high. The output side has no ready signal. Flow on that side is governed by credits. A flit is presented on `out_valid` only when the output holds a credit, and the downstream side takes every flit presented. The downstream side returns one credit per `credit_ret` pulse.

Top module: `xsw_switch`

## Requirements
- R1: In the first cycle after synchronous reset is released, every `out_valid` bit is 0 and every `in_ready` bit is 1. Each output then holds CREDITS credits.
- R2: A flit with `in_head`=1 is steered to the output numbered by bits [3:0] of its data word. That flit leaves with its data shifted right by 4 bits (zero filled). Body flits and the tail flit leave with their data unchanged.
- R3: When one output has no credits, flits queued at the same input for other outputs still leave; there is no head-of-line blocking between outputs.
- R4: Each per-output queue at an input holds VOQ_DEPTH flits. While the queue a flit is steered to is full, `in_ready` for that input is 0 and the flit is not taken.
- R5: Flits from one input to one output leave in the order they were taken, with their flags intact. Every flit that was taken and not discarded eventually leaves.
- R6: An output carries a head flit only when no packet is open on it. After a head flit without a tail leaves, every further flit on that output comes from the same input and has head=0, up to and including the tail flit.
- R7: Each output serves competing inputs in round-robin order. After a packet ends, the input with the next higher index (wrapping from 8 to 0) that has a flit waiting is served first.
- R8: Each output's credit count starts at CREDITS. Each flit sent takes one credit and each `credit_ret` pulse gives one back. A flit sent and a pulse received in the same cycle leave the count unchanged. No flit is sent at zero credits, and a pulse that arrives when the count is already CREDITS is ignored.
- R9: A flit taken at a clock edge shows on `out_valid` in the very next cycle, provided its output is free and holds a credit. This lets a head leave before its tail arrives.
- R10: A packet whose head port field is 9 or higher is taken at full rate, with `in_ready` held high, and discarded up to its tail. None of its flits appears on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NPORT | Per-input flit offered |
| in_data | input | NPORT*DW | Per-input flit data word |
| in_head | input | NPORT | Per-input head-flit flag |
| in_tail | input | NPORT | Per-input tail-flit flag |
| in_ready | output | NPORT | Per-input flit accepted when high together with valid |
| out_valid | output | NPORT | Per-output flit sent this cycle |
| out_data | output | NPORT*DW | Per-output flit data word |
| out_head | output | NPORT | Per-output head-flit flag |
| out_tail | output | NPORT | Per-output tail-flit flag |
| credit_ret | input | NPORT | Per-output credit returned by the downstream buffer |

## Verification
The bench builds the switch with nine ports, 32-bit flits, a queue depth of 4 and only 3 credits per output. The small credit pool means an output runs dry after three flits when credits are held back. The shallow queues then fill one cycle per flit, so the stalled-input, saturated-credit and blocked-output cases are each reached within a handful of cycles. With nine inputs contending for shared outputs, both the rotating arbiter order and the holding of an output until a tail are exercised many times during the random phase.

// File: rtl/xsw_pkg.sv
package xsw_pkg;

  // Two flag bits (head, tail) travel beside every flit word.
  localparam int FLAG_W = 2;

  typedef enum logic {
    ST_OPEN,
    ST_LOCKED
  } lock_state_e;

endpackage

// File: rtl/xsw_voq_fifo.sv
module xsw_voq_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] fill;
  logic          do_push;
  logic          do_pop;

  assign full    = (fill == FULL_CNT);
  assign empty   = (fill == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

endmodule

// File: rtl/xsw_credit_ctr.sv
module xsw_credit_ctr #(
  parameter int CREDITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic give,
  output logic avail
);

  localparam int CW = $clog2(CREDITS + 1);
  localparam logic [CW-1:0] CMAX = CW'(CREDITS);

  logic [CW-1:0] count;

  assign avail = (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= CMAX;
    end else begin
      case ({take, give})
        2'b10:   count <= count - CW'(1);
        2'b01:   count <= (count < CMAX) ? count + CW'(1) : count;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/xsw_in_port.sv
module xsw_in_port
  import xsw_pkg::*;
#(
  parameter int NP    = 9,
  parameter int DW    = 32,
  parameter int PW    = 4,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [DW-1:0]          in_data,
  input  logic                   in_head,
  input  logic                   in_tail,
  output logic                   in_ready,
  output logic [NP-1:0]          voq_req,
  output logic [NP-1:0][DW-1:0]  voq_data,
  output logic [NP-1:0]          voq_head,
  output logic [NP-1:0]          voq_tail,
  input  logic [NP-1:0]          voq_pop
);

  localparam int QW = DW + FLAG_W;

  logic [PW-1:0] hdr_port;
  logic          hdr_bad;
  logic [PW-1:0] cur_port;
  logic          cur_drop;
  logic [PW-1:0] port_sel;
  logic          drop_now;
  logic          sel_full;
  logic          accept;
  logic [QW-1:0] wr_word;
  logic [NP-1:0] push;
  logic [NP-1:0] q_full;
  logic [NP-1:0] q_empty;
  logic [QW-1:0] rd_word [NP];

  assign hdr_port = in_data[PW-1:0];
  assign hdr_bad  = (int'(hdr_port) >= NP);
  assign port_sel = in_head ? hdr_port : cur_port;
  assign drop_now = in_head ? hdr_bad : cur_drop;

  always_comb begin
    sel_full = 1'b0;
    for (int j = 0; j < NP; j++) begin
      if (port_sel == PW'(j)) sel_full = q_full[j];
    end
  end

  assign in_ready = drop_now | ~sel_full;
  assign accept   = in_valid & in_ready;
  assign wr_word  = {in_head, in_tail, (in_head ? (in_data >> PW) : in_data)};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_port <= '0;
      cur_drop <= 1'b0;
    end else if (accept && in_head) begin
      cur_port <= hdr_port;
      cur_drop <= hdr_bad;
    end
  end

  for (genvar j = 0; j < NP; j++) begin : g_voq
    assign push[j] = accept & ~drop_now & (port_sel == PW'(j));

    xsw_voq_fifo #(
      .W    (QW),
      .DEPTH(DEPTH)
    ) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .push   (push[j]),
      .wr_data(wr_word),
      .pop    (voq_pop[j]),
      .rd_data(rd_word[j]),
      .full   (q_full[j]),
      .empty  (q_empty[j])
    );

    assign voq_req[j]  = ~q_empty[j];
    assign voq_head[j] = rd_word[j][DW+1];
    assign voq_tail[j] = rd_word[j][DW];
    assign voq_data[j] = rd_word[j][DW-1:0];
  end

endmodule

// File: rtl/xsw_out_port.sv
module xsw_out_port
  import xsw_pkg::*;
#(
  parameter int NP      = 9,
  parameter int DW      = 32,
  parameter int CREDITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NP-1:0]         req,
  input  logic [NP-1:0][DW-1:0] data,
  input  logic [NP-1:0]         head,
  input  logic [NP-1:0]         tail,
  input  logic                  credit_ret,
  output logic [NP-1:0]         pop,
  output logic                  out_valid,
  output logic [DW-1:0]         out_data,
  output logic                  out_head,
  output logic                  out_tail
);

  localparam int IW = (NP > 1) ? $clog2(NP) : 1;
  localparam logic [IW-1:0] LAST_IN = IW'(NP - 1);

  lock_state_e   state;
  logic [IW-1:0] owner;
  logic [IW-1:0] rr_ptr;
  logic [IW-1:0] pick;
  logic          found;
  logic [IW-1:0] sel;
  logic          have;
  logic          credit_ok;
  int            scan;

  // Rotating search for the first requester at or after the pointer.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    scan  = 0;
    for (int k = 0; k < NP; k++) begin
      scan = int'(rr_ptr) + k;
      if (scan >= NP) scan = scan - NP;
      if (!found && req[scan]) begin
        found = 1'b1;
        pick  = IW'(scan);
      end
    end
  end

  assign sel       = (state == ST_LOCKED) ? owner : pick;
  assign have      = (state == ST_LOCKED) ? req[sel] : found;
  assign out_valid = have & credit_ok;
  assign out_data  = data[sel];
  assign out_head  = head[sel];
  assign out_tail  = tail[sel];

  always_comb begin
    pop = '0;
    if (out_valid) pop[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_OPEN;
      owner  <= '0;
      rr_ptr <= '0;
    end else if (out_valid) begin
      if (out_tail) begin
        state  <= ST_OPEN;
        rr_ptr <= (sel == LAST_IN) ? '0 : sel + IW'(1);
      end else if (out_head) begin
        state <= ST_LOCKED;
        owner <= sel;
      end
    end
  end

  xsw_credit_ctr #(
    .CREDITS(CREDITS)
  ) u_credit (
    .clk  (clk),
    .rst  (rst),
    .take (out_valid),
    .give (credit_ret),
    .avail(credit_ok)
  );

endmodule

// File: rtl/xsw_switch.sv
module xsw_switch #(
  parameter int NPORT     = 9,
  parameter int DW        = 32,
  parameter int PW        = 4,
  parameter int VOQ_DEPTH = 4,
  parameter int CREDITS   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORT-1:0]         in_valid,
  input  logic [NPORT-1:0][DW-1:0] in_data,
  input  logic [NPORT-1:0]         in_head,
  input  logic [NPORT-1:0]         in_tail,
  output logic [NPORT-1:0]         in_ready,
  output logic [NPORT-1:0]         out_valid,
  output logic [NPORT-1:0][DW-1:0] out_data,
  output logic [NPORT-1:0]         out_head,
  output logic [NPORT-1:0]         out_tail,
  input  logic [NPORT-1:0]         credit_ret
);

  // Per-input views (index: input, then output inside the vector).
  logic [NPORT-1:0]         q_req  [NPORT];
  logic [NPORT-1:0][DW-1:0] q_data [NPORT];
  logic [NPORT-1:0]         q_head [NPORT];
  logic [NPORT-1:0]         q_tail [NPORT];
  logic [NPORT-1:0]         q_pop  [NPORT];

  // Per-output views (index: output, then input inside the vector).
  logic [NPORT-1:0]         x_req  [NPORT];
  logic [NPORT-1:0][DW-1:0] x_data [NPORT];
  logic [NPORT-1:0]         x_head [NPORT];
  logic [NPORT-1:0]         x_tail [NPORT];
  logic [NPORT-1:0]         x_pop  [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    xsw_in_port #(
      .NP   (NPORT),
      .DW   (DW),
      .PW   (PW),
      .DEPTH(VOQ_DEPTH)
    ) u_in (
      .clk     (clk),
      .rst     (rst),
      .in_valid(in_valid[i]),
      .in_data (in_data[i]),
      .in_head (in_head[i]),
      .in_tail (in_tail[i]),
      .in_ready(in_ready[i]),
      .voq_req (q_req[i]),
      .voq_data(q_data[i]),
      .voq_head(q_head[i]),
      .voq_tail(q_tail[i]),
      .voq_pop (q_pop[i])
    );
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_xpose
    for (genvar i = 0; i < NPORT; i++) begin : g_cell
      assign x_req[o][i]  = q_req[i][o];
      assign x_data[o][i] = q_data[i][o];
      assign x_head[o][i] = q_head[i][o];
      assign x_tail[o][i] = q_tail[i][o];
      assign q_pop[i][o]  = x_pop[o][i];
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    xsw_out_port #(
      .NP     (NPORT),
      .DW     (DW),
      .CREDITS(CREDITS)
    ) u_out (
      .clk       (clk),
      .rst       (rst),
      .req       (x_req[o]),
      .data      (x_data[o]),
      .head      (x_head[o]),
      .tail      (x_tail[o]),
      .credit_ret(credit_ret[o]),
      .pop       (x_pop[o]),
      .out_valid (out_valid[o]),
      .out_data  (out_data[o]),
      .out_head  (out_head[o]),
      .out_tail  (out_tail[o])
    );
  end

endmodule

// File: rtl/xsw_switch_chk.sv
module xsw_switch_chk #(
  parameter int NPORT   = 9,
  parameter int CREDITS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] in_ready,
  input logic [NPORT-1:0] out_valid,
  input logic [NPORT-1:0] out_head,
  input logic [NPORT-1:0] out_tail,
  input logic [NPORT-1:0] credit_ret
);

  localparam int CW = $clog2(CREDITS + 1);
  localparam logic [CW-1:0] CMAX = CW'(CREDITS);

  // R1: idle outputs and open inputs right after reset.
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0 && in_ready == '1))
    else $error("switch not idle after reset");

  for (genvar o = 0; o < NPORT; o++) begin : g_mon
    logic [CW-1:0] shadow;
    logic          open_pkt;

    // Independent credit ledger built from the port activity only.
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow   <= CMAX;
        open_pkt <= 1'b0;
      end else begin
        if (out_valid[o] && !credit_ret[o])
          shadow <= shadow - CW'(1);
        else if (!out_valid[o] && credit_ret[o] && shadow < CMAX)
          shadow <= shadow + CW'(1);
        if (out_valid[o]) begin
          if (out_tail[o])      open_pkt <= 1'b0;
          else if (out_head[o]) open_pkt <= 1'b1;
        end
      end
    end

    // R8: never send without a credit.
    assert_credit_held_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] |-> (shadow != '0))
      else $error("flit sent with no credit on output %0d", o);

    // R6: no new head while a packet is open.
    assert_no_head_mid_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && open_pkt) |-> !out_head[o])
      else $error("head inside open packet on output %0d", o);

    // R6: a packet begins with a head flit.
    assert_pkt_start_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !open_pkt) |-> out_head[o])
      else $error("packet without head on output %0d", o);
  end

endmodule

bind xsw_switch xsw_switch_chk #(
  .NPORT  (NPORT),
  .CREDITS(CREDITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_head  (out_head),
  .out_tail  (out_tail),
  .credit_ret(credit_ret)
);

// File: tb/xsw_switch_tb.sv
`timescale 1ns/1ps
module xsw_switch_tb;

  localparam int NP = 9;
  localparam int DW = 32;
  localparam int PW = 4;
  localparam int QD = 4;
  localparam int CR = 3;

  logic                  clk = 1'b0;
  logic                  rst;
  logic [NP-1:0]         in_valid;
  logic [NP-1:0][DW-1:0] in_data;
  logic [NP-1:0]         in_head;
  logic [NP-1:0]         in_tail;
  logic [NP-1:0]         in_ready;
  logic [NP-1:0]         out_valid;
  logic [NP-1:0][DW-1:0] out_data;
  logic [NP-1:0]         out_head;
  logic [NP-1:0]         out_tail;
  logic [NP-1:0]         credit_ret;

  always #2 clk = ~clk;

  xsw_switch #(.NPORT(NP), .DW(DW), .PW(PW), .VOQ_DEPTH(QD), .CREDITS(CR)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_head(in_head),
    .in_tail(in_tail), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_head(out_head), .out_tail(out_tail), .credit_ret(credit_ret));

  // Sender streams {head, tail, data} with destination; expected output queues.
  logic [DW+1:0] sq [NP][$];
  int            sd [NP][$];
  logic [DW+1:0] eq [NP][NP][$];

  int checks = 0, errors = 0, cyc = 0;
  int pending [NP];
  int sent_cnt [NP];
  int first_seen [NP];
  logic [DW-1:0] first_data [NP];
  int acc_cycle [NP];
  bit mid [NP];
  int owner [NP];
  bit offered [NP];
  int rr_log [$];
  bit auto_ret = 1'b0;
  int valid_pct = 100;
  logic [NP-1:0] extra_ret = '0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk_head(int dst, int src, int nxt);
    return {16'($urandom), 4'(src), 4'($urandom), 4'(nxt), 4'(dst)};
  endfunction

  function automatic logic [DW-1:0] mk_body(int src);
    return {20'($urandom), 4'(src), 8'($urandom)};
  endfunction

  task automatic add_pkt(int src, int dst, int len, int nxt);
    for (int k = 0; k < len; k++) begin
      logic h, t;
      logic [DW-1:0] d;
      h = (k == 0);
      t = (k == len - 1);
      d = h ? mk_head(dst, src, nxt) : mk_body(src);
      sq[src].push_back({h, t, d});
      sd[src].push_back(dst);
    end
  endtask

  function automatic bit all_idle();
    for (int i = 0; i < NP; i++) begin
      if (sq[i].size() != 0) return 1'b0;
      for (int j = 0; j < NP; j++) if (eq[i][j].size() != 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic tick();
    @(negedge clk);
    cyc++;
    for (int j = 0; j < NP; j++) begin
      bit r;
      r = auto_ret && pending[j] > 0 && ($urandom_range(0, 1) == 1);
      if (r) pending[j]--;
      credit_ret[j] = r | extra_ret[j];
    end
    for (int j = 0; j < NP; j++) begin
      if (out_valid[j]) begin
        int s;
        s = int'(out_data[j][11:8]);
        sent_cnt[j]++;
        pending[j]++;
        if (first_seen[j] < 0) begin
          first_seen[j] = cyc;
          first_data[j] = out_data[j];
        end
        if (j == 0) rr_log.push_back(s);
        if (mid[j]) chk(s == owner[j] && !out_head[j], "R6", "locked output source", s, owner[j]);
        else        chk(out_head[j] == 1'b1, "R6", "packet start head flag", out_head[j], 1);
        if (s >= NP || eq[s][j].size() == 0) begin
          chk(1'b0, "R2", "unexpected flit on output", out_data[j], j);
        end else begin
          logic [DW+1:0] e;
          e = eq[s][j].pop_front();
          chk({out_head[j], out_tail[j], out_data[j]} == e, "R5", "flit content/order",
              {out_head[j], out_tail[j], out_data[j]}, e);
        end
        if (out_tail[j]) mid[j] = 1'b0;
        else if (out_head[j]) begin
          mid[j] = 1'b1;
          owner[j] = s;
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      if (!offered[i] && sq[i].size() > 0 && $urandom_range(0, 99) < valid_pct)
        offered[i] = 1'b1;
      if (offered[i]) begin
        in_valid[i] = 1'b1;
        {in_head[i], in_tail[i], in_data[i]} = sq[i][0];
      end else begin
        in_valid[i] = 1'b0;
        in_head[i]  = 1'b0;
        in_tail[i]  = 1'b0;
        in_data[i]  = '0;
      end
    end
    #1;
    for (int i = 0; i < NP; i++) begin
      if (in_valid[i] && in_ready[i]) begin
        logic [DW+1:0] f;
        int d;
        f = sq[i].pop_front();
        d = sd[i].pop_front();
        offered[i] = 1'b0;
        if (f[DW+1]) acc_cycle[i] = cyc;
        if (d < NP) eq[i][d].push_back({f[DW+1], f[DW], (f[DW+1] ? (f[DW-1:0] >> PW) : f[DW-1:0])});
      end
    end
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd51477);
    for (int j = 0; j < NP; j++) begin
      pending[j] = 0; sent_cnt[j] = 0; first_seen[j] = -1; acc_cycle[j] = -1;
      mid[j] = 1'b0; owner[j] = 0; offered[j] = 1'b0; first_data[j] = '0;
    end
    rst = 1'b1;
    in_valid = '0; in_data = '0; in_head = '0; in_tail = '0; credit_ret = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk(out_valid == '0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == '1, "R1", "in_ready after reset", in_ready, 9'h1ff);

    // R9 / R2: cut-through latency and header rewrite
    auto_ret = 1'b1;
    add_pkt(1, 5, 3, 6);
    run(10);
    chk(first_seen[5] == acc_cycle[1] + 1, "R9", "head latency", first_seen[5], acc_cycle[1] + 1);
    chk(first_data[5][3:0] == 4'd6, "R2", "next hop field after shift", first_data[5][3:0], 6);
    chk(first_data[5][11:8] == 4'd1, "R2", "shifted source tag", first_data[5][11:8], 1);

    // R7: round-robin among inputs 5,6,7 on output 0
    for (int r = 0; r < 3; r++) begin
      add_pkt(5, 0, 1, 0); add_pkt(6, 0, 1, 0); add_pkt(7, 0, 1, 0);
    end
    run(40);
    chk(rr_log.size() == 9, "R7", "output 0 flit count", rr_log.size(), 9);
    for (int k = 0; k < rr_log.size() && k < 9; k++)
      chk(rr_log[k] == 5 + (k % 3), "R7", "round-robin order", rr_log[k], 5 + (k % 3));

    // R8: extra returns on a full counter are ignored
    auto_ret = 1'b0;
    extra_ret = 9'(1 << 7);
    run(2);
    extra_ret = '0;
    add_pkt(4, 7, CR + 2, 0);
    run(20);
    chk(sent_cnt[7] == CR, "R8", "flits sent after saturating returns", sent_cnt[7], CR);

    // R8 / R4: credit exhaustion fills the queue and stalls the input
    add_pkt(0, 3, CR + QD + 2, 0);
    run(20);
    chk(sent_cnt[3] == CR, "R8", "flits sent with no returns", sent_cnt[3], CR);
    chk(in_valid[0] && !in_ready[0], "R4", "input stalled on full queue", in_ready[0], 0);
    chk(sq[0].size() == 2, "R4", "flits left with sender", sq[0].size(), 2);

    // R3: blocked output does not stall another output from the same input
    add_pkt(2, 3, 2, 0);
    add_pkt(2, 6, 3, 0);
    run(15);
    chk(sent_cnt[6] == 3, "R3", "flits through unblocked output", sent_cnt[6], 3);
    chk(sent_cnt[3] == CR, "R6", "blocked output held by owner", sent_cnt[3], CR);

    // R10: out-of-range port packet is swallowed
    add_pkt(8, 12, 3, 0);
    add_pkt(8, 1, 2, 0);
    run(12);
    chk(sq[8].size() == 0, "R10", "sender drained", sq[8].size(), 0);
    chk(sent_cnt[1] == 2, "R10", "only valid packet delivered", sent_cnt[1], 2);

    // Random phase with credit returns
    auto_ret = 1'b1;
    valid_pct = 60;
    for (int p = 0; p < 250; p++)
      add_pkt($urandom_range(0, NP - 1), $urandom_range(0, NP - 1), $urandom_range(1, 4),
              $urandom_range(0, 15));
    for (int t = 0; t < 40000 && !all_idle(); t++) tick();
    run(10);
    chk(all_idle(), "R5", "all accepted flits delivered", 0, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule